// File: doc/BRIEF.md
# Multi-Channel Prescaled Timer Unit

This block is a memory-mapped timer peripheral. A shared tick generator divides the reference clock into four decade timebase strobes: 1 us, 10 us, 100 us and 1 ms. Each of a parameterised number of 16-bit event channels counts down at one of these rates. When a channel expires it raises a one-cycle interrupt pulse. It then either reloads and keeps firing (periodic mode) or parks at zero (one-shot mode).

Alongside the channels runs a 32-bit timestamp counter. It advances on the raw clock or on any of the decade strobes, so software always has a monotonic time base to read. All configuration sits in one control word. Each channel also has its own count register. Software reaches these through a simple word-addressed write/read port whose read data is combinational.

The reference clock rate is set with `REF_PER_US`, the number of clock cycles in one microsecond.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the control word, timestamp and every channel count read as zero, and all interrupt outputs are low.
- R2: A channel resolution code of 0, 1, 2 or 3 selects a tick period of 1, 10, 100 or 1000 us, where 1 us is `REF_PER_US` clock cycles. For channel i the code is control bits [2i+1:2i].
- R3: In periodic mode (control bit 12+i set), a channel loaded with N raises interrupts exactly (N+1) tick periods apart.
- R4: After a count write of N, the first interrupt follows the (N+1)-th tick after the write. The pulse appears one clock after that tick.
- R5: In one-shot mode (control bit 12+i clear), a channel fires once, then reads zero and stays silent until its count register is written again.
- R6: While a channel's enable (control bit 16+i) is clear, its count is frozen and it raises no interrupt. Setting the enable again resumes the countdown from the frozen value.
- R7: Writing a channel's count register while the channel runs restarts the countdown from the new value.
- R8: Every interrupt is a single-cycle high pulse.
- R9: Timestamp resolution is control bits [10:8]. Code 0 advances the counter every clock, and codes 1 to 4 advance it once per 1 us, 10 us, 100 us or 1 ms tick. Codes 5 to 7 leave it unchanged.
- R10: When control bit 20 is clear, the timestamp holds its value.
- R11: The word addresses are as follows.
  - Address 0 is the control word, which can be read and written.
  - Address 1 reads the timestamp.
  - Address 2+i is channel i's count. A write loads bits [15:0]. A read returns the current count in bits [15:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | NUM_CH | Per-channel one-cycle expiry pulse |

## Verification
The bench measures the spacing of periodic interrupts in every resolution, including a reload value of zero. A channel that counted N ticks instead of N+1, or that drew on the wrong strobe, would show an interval off by one tick or by a factor of ten. One-shot channels are watched after expiry: a channel that failed to disarm would fire again or read a non-zero count. A channel is disabled mid-count and later re-enabled; a design that kept counting while disabled, or lost its state, would read a different count. The timestamp is sampled over fixed windows in each resolution, with an out-of-range code and with its enable clear, to catch wrong strobe selection and counting while stopped.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the timer unit.
// Assumes exactly four decade timebases (1 us .. 1 ms).
package tmr_pkg;
    localparam int unsigned NUM_RATES = 4;
    localparam int unsigned CNT_W     = 16;
    localparam int unsigned TS_W      = 32;
    typedef logic [NUM_RATES-1:0] tick_vec_t;
    typedef logic [CNT_W-1:0]     cnt_t;
endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
// Decade tick generator: a prescaler makes a 1 us strobe, and each further
// stage divides the previous strobe by ten. Each strobe is high for one cycle.
// Assumes REF_PER_US >= 2, so that strobes never sit high on back-to-back cycles.
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int unsigned REF_PER_US = 100
) (
    input  logic      clk,
    input  logic      rst_n,
    output tick_vec_t strobe
);
    localparam int unsigned PW = (REF_PER_US > 2) ? $clog2(REF_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(REF_PER_US - 1);

    logic [PW-1:0] pre;

    // prescaler counting reference cycles within one microsecond
    always_ff @(posedge clk) begin
        if (!rst_n)               pre <= '0;
        else if (pre == PRE_LAST) pre <= '0;
        else                      pre <= pre + 1'b1;
    end

    assign strobe[0] = (pre == PRE_LAST);

    for (genvar d = 1; d < NUM_RATES; d++) begin : g_decade
        logic [3:0] dc;
        // divide-by-ten stage counting strobes of the previous rate
        always_ff @(posedge clk) begin
            if (!rst_n)            dc <= '0;
            else if (strobe[d-1])  dc <= (dc == 4'd9) ? 4'd0 : dc + 4'd1;
        end
        assign strobe[d] = strobe[d-1] && (dc == 4'd9);
    end

    // R2
    us_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[0] |=> !strobe[0]);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One 16-bit down-counting event channel. A load arms the channel with a new
// value. On each selected tick it decrements, and the tick at zero fires a
// one-cycle interrupt, then reloads (periodic) or disarms (one-shot).
// Assumes the selected strobe is never high on two cycles in a row.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      periodic,
    input  logic [1:0] res,
    input  tick_vec_t strobe,
    input  logic      load,
    input  cnt_t      load_val,
    output cnt_t      cnt,
    output logic      irq
);
    cnt_t reload;
    logic armed;
    logic tick;

    assign tick = strobe[res];

    // countdown, reload and interrupt pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            reload <= '0;
            armed  <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                cnt    <= load_val;
                reload <= load_val;
                armed  <= 1'b1;
            end else if (en && tick && armed) begin
                if (cnt == '0) begin
                    irq <= 1'b1;
                    if (periodic) cnt   <= reload;
                    else          armed <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> ($stable(cnt) && !irq));
    // R5
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && armed && cnt == '0 && !periodic && !load) |=> (cnt == '0 && !armed));
endmodule

// File: rtl/tmr_timestamp.sv
`timescale 1ns/1ps
// 32-bit free-running timestamp. Resolution code 0 counts every clock and
// codes 1..4 count decade strobes. Other codes, or enable low, hold the value.
// The count wraps modulo 2^32.
module tmr_timestamp
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [2:0]      res,
    input  tick_vec_t       strobe,
    output logic [TS_W-1:0] ts
);
    logic       step;
    logic [1:0] sidx;

    assign sidx = res[1:0] - 2'd1;

    // choose the advance condition from the resolution code
    always_comb begin
        if (!en)                          step = 1'b0;
        else if (res == 3'd0)             step = 1'b1;
        else if (res <= 3'd4)             step = strobe[sidx];
        else                              step = 1'b0;
    end

    // timestamp register
    always_ff @(posedge clk) begin
        if (!rst_n)    ts <= '0;
        else if (step) ts <= ts + 1'b1;
    end

    // R9
    ts_sysclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && res == 3'd0) |=> (ts == $past(ts) + 1'b1));
    // R10
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ts));
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
// Timer unit top: control word, register port, tick generator, event
// channels and timestamp. Channel i takes its resolution from
// ctrl[CH_RES_LSB+2i +: 2], its mode from ctrl[CH_MODE_LSB+i] and its enable
// from ctrl[CH_EN_LSB+i]. The timestamp uses ctrl[TS_RES_LSB +: 3] and
// ctrl[TS_EN_BIT]. Assumes the parameters keep these fields from overlapping.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int unsigned REF_PER_US  = 100,
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned CH_RES_LSB  = 0,
    parameter int unsigned CH_MODE_LSB = 12,
    parameter int unsigned CH_EN_LSB   = 16,
    parameter int unsigned TS_RES_LSB  = 8,
    parameter int unsigned TS_EN_BIT   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TS   = ADDR_W'(1);
    localparam int unsigned       A_CH0  = 2;

    logic [31:0]     ctrl;
    tick_vec_t       strobe;
    logic [TS_W-1:0] ts;
    cnt_t            ch_cnt [NUM_CH];

    // control word register
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl <= '0;
        else if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata;
    end

    tmr_tick_gen #(.REF_PER_US(REF_PER_US)) u_ticks (
        .clk(clk), .rst_n(rst_n), .strobe(strobe)
    );

    tmr_timestamp u_ts (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl[TS_EN_BIT]), .res(ctrl[TS_RES_LSB +: 3]),
        .strobe(strobe), .ts(ts)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ld;
        assign ld = bus_wr && (bus_addr == ADDR_W'(A_CH0 + i));
        tmr_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .en(ctrl[CH_EN_LSB + i]),
            .periodic(ctrl[CH_MODE_LSB + i]),
            .res(ctrl[CH_RES_LSB + 2*i +: 2]),
            .strobe(strobe),
            .load(ld), .load_val(bus_wdata[CNT_W-1:0]),
            .cnt(ch_cnt[i]), .irq(irq[i])
        );
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) bus_rdata = ctrl;
        if (bus_addr == A_TS)   bus_rdata = ts;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == ADDR_W'(A_CH0 + i)) bus_rdata = {16'b0, ch_cnt[i]};
    end
endmodule

// File: tb/tmr_unit_test.sv
`timescale 1ns/1ps
module tmr_unit_test;
    localparam int P_US = 4;
    logic clk = 0, rst_n = 0, bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [1:0] irq;
    int errors = 0, checks = 0, n0 = 0, n1 = 0;
    logic p0 = 0, p1 = 0;

    always #2 clk = ~clk; // 250 MHz

    tmr_unit #(.REF_PER_US(P_US)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    // {channel, resolution code, reload value}
    localparam logic [18:0] VEC [5] = '{
        {1'b0, 2'd0, 16'd9}, {1'b0, 2'd1, 16'd3}, {1'b1, 2'd2, 16'd1},
        {1'b1, 2'd3, 16'd0}, {1'b0, 2'd0, 16'd0}};

    // pulse counters and back-to-back detection (R8)
    always @(negedge clk) begin
        if (irq[0]) n0++;
        if (irq[1]) n1++;
        if ((irq[0] && p0) || (irq[1] && p1)) begin
            checks++; errors++;
            $display("FAIL R8 interrupt high two cycles: irq=%b prev=%b%b exp single pulse", irq, p1, p0);
        end
        p0 = irq[0]; p1 = irq[1];
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 3'(a); bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 3'(a); #1; d = bus_rdata;
    endtask

    // edges after the write edge until irq[ch] seen high
    task automatic wait_irq(input int ch, output int c);
        c = 1;
        while (!irq[ch] && c < 20000) begin @(negedge clk); c++; end
    endtask

    function automatic int period(input int r);
        int p = P_US;
        for (int k = 0; k < r; k++) p = p * 10;
        return p;
    endfunction

    task automatic ts_win(input logic [31:0] c, input int cyc, input int exp, input string tag);
        logic [31:0] a, b;
        wr(0, c);
        rd(1, a);
        repeat (cyc) @(negedge clk);
        rd(1, b);
        chk(b - a == 32'(exp), tag, b - a, exp);
    endtask

    initial begin
        #(4 * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, a, b;
        int c, s, np, per, n, ch, r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd(k, d); chk(d == 0, "R1 register after reset", d, 0);
        end
        chk(irq == 0, "R1 irq after reset", irq, 0);

        // vector walk: periodic intervals per resolution (R2 R3 R4 R11)
        for (int v = 0; v < 5; v++) begin
            ch = int'(VEC[v][18]); r = int'(VEC[v][17:16]); n = int'(VEC[v][15:0]);
            per = period(r);
            wr(0, (32'(r) << (2*ch)) | (32'h1000 << ch) | (32'h10000 << ch));
            wr(2 + ch, 32'(n));
            wait_irq(ch, c);
            chk(c >= n*per + 2 && c <= (n+1)*per + 1, "R4 first expiry window", c, (n+1)*per);
            @(negedge clk);
            wait_irq(ch, c);
            chk(c == (n+1)*per, "R3 R2 periodic interval", c, (n+1)*per);
        end
        wr(0, 0);

        // R5 one-shot on channel 0
        wr(0, 32'h10000);
        wr(2, 32'd5);
        wait_irq(0, c);
        chk(c >= 5*P_US + 2 && c <= 6*P_US + 1, "R5 one-shot first expiry", c, 6*P_US);
        @(negedge clk);
        s = n0;
        repeat (100) @(negedge clk);
        chk(n0 == s, "R5 no refire after one-shot", n0, s);
        rd(2, d); chk(d == 0, "R5 parked count", d, 0);

        // R6 freeze on channel 1, resolution 1 us
        wr(0, 32'h20000);
        wr(3, 32'd200);
        repeat (20) @(negedge clk);
        wr(0, 0);
        rd(3, a);
        s = n1;
        repeat (60) @(negedge clk);
        rd(3, b);
        chk(b == a, "R6 count frozen while disabled", b, a);
        chk(a < 200 && a > 150, "R6 count advanced before disable", a, 195);
        chk(n1 == s, "R6 no irq while disabled", n1, s);
        wr(0, 32'h20000);
        rd(3, a);
        repeat (40) @(negedge clk);
        rd(3, b);
        chk(b == a - 10, "R6 resume from frozen value", b, a - 10);
        wr(0, 0);

        // R7 restart while running
        wr(0, 32'h10000);
        wr(2, 32'd500);
        repeat (100) @(negedge clk);
        wr(2, 32'd3);
        wait_irq(0, c);
        chk(c >= 3*P_US + 2 && c <= 4*P_US + 1, "R7 restart expiry window", c, 4*P_US);
        wr(0, 0);

        // R9 R10 timestamp
        ts_win(32'h100000, 10, 10, "R9 sysclk resolution");
        ts_win(32'h100100, 40, 10, "R9 1us resolution");
        ts_win(32'h100300, 800, 2, "R9 100us resolution");
        ts_win(32'h100400, 8000, 2, "R9 1ms resolution");
        ts_win(32'h100500, 50, 0, "R9 reserved code holds");
        ts_win(32'h000000, 50, 0, "R10 disabled holds");
        rd(0, d); chk(d == 0, "R11 control readback", d, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule